// File: doc/BRIEF.md
# Duplicate-Tag Snoop Filter

This block answers coherence lookups for a cluster of four cores, each of which has a private L2. For every one of those L2s it keeps a private shadow copy of that L2's tag array. A lookup therefore never takes a tag-read slot away from any L2. Each core sends line-address requests, and each L2 reports its fills and evictions so that its shadow copy stays in step.

For every accepted request the filter returns one of two results. A hit means another core's L2 holds the line, and the reply names that core so the line can move cache to cache without touching the shared L3. A miss means no other L2 has the line, and only then may the L3 lookup for that request be issued.

The shadow tags are split into four banks, selected by the low bits of the set index. A request that meets another request in the same bank in the same cycle waits for the next pass. The tag check runs in two stages. The first stage compares a few low tag bits to narrow the candidate ways. The second stage confirms the candidates against the full tag. A request whose set has a shadow-tag update in flight is held back with valid/ready until that update has been written.

Top module: `snoop_filter`

## Requirements
- R1: A response appears on the requesting core's result port exactly two clock edges after the edge on which its request handshake (valid and ready both high) completes, stays valid for one cycle, and returns the request tag that came with the request.
- R2: The result is a hit (hit flag 1) when some other core's shadow array holds a valid entry whose full tag equals the request's tag in the request's set. The owner vector then has exactly the bit of the lowest-numbered such core set. Otherwise hit is 0 and the owner vector is all zeros, which allows the L3 lookup.
- R3: The requesting core's own shadow array never produces a hit or an owner bit for that core's request.
- R4: A fill from core c writes the tag of the given address into the given way of its set in core c's shadow array and marks it valid. An eviction clears the valid bit of the given way. A later fill to the same way replaces the earlier tag.
- R5: Address bits [SET_W-1:0] form the set index and the bits above them form the tag. A stored tag that agrees with the request only in its low PTAG_W bits (4 by default) does not produce a hit.
- R6: The bank is address bits [1:0]. When several cores present valid requests to the same bank in one cycle, only the lowest-numbered of them sees ready. The others are accepted on later cycles.
- R7: Requests to different banks in the same cycle are all accepted in that cycle.
- R8: A request is not accepted in a cycle where any core presents an update to the same set, nor in the following cycle while that update is pending. It is accepted in the cycle after that, and its result reflects the update.
- R9: After reset no response is valid and every shadow array is empty, so every lookup misses.
- R10: A response is given only on the port of the core that issued the request, and only for an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Per-core lookup request valid |
| req_ready | output | NCORE | Per-core request accepted this cycle |
| req_addr | input | NCORE x ADDR_W | Per-core line address |
| req_rtag | input | NCORE x RTAG_W | Per-core request tag, echoed in the response |
| upd_valid | input | NCORE | Per-core shadow tag update valid |
| upd_fill | input | NCORE | 1 = fill, 0 = eviction |
| upd_addr | input | NCORE x ADDR_W | Line address of the update |
| upd_way | input | NCORE x WAY_W | Way written or cleared |
| rsp_valid | output | NCORE | Per-core response valid |
| rsp_hit | output | NCORE | Line held by another L2 (cache-to-cache) |
| rsp_owner | output | NCORE x NCORE | One-hot owner core per response |
| rsp_rtag | output | NCORE x RTAG_W | Echoed request tag |

## Verification
The assertions assume that the requester does not change its address or tag while valid is high and ready is low. They also assume that updates are only presented after reset has been released. The bench keeps each request stable until its handshake completes, and it drives updates only after reset, one cycle per update. The shadow-array model in the bench holds a single copy of each line per way. For this reason the stimulus never fills the same line into two ways of one core, because a real L2 never does that.

// File: rtl/snpf_pkg.sv
package snpf_pkg;
   typedef enum logic {UPD_DROP = 1'b0, UPD_LOAD = 1'b1} upd_kind_e;

   function automatic int clog2_min1(int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/snpf_dup_array.sv
module snpf_dup_array
   import snpf_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SET_W  = 4,
   parameter int WAYS   = 4,
   parameter int NBANK  = 4,
   localparam int TAG_W = ADDR_W - SET_W,
   localparam int WAY_W = clog2_min1(WAYS),
   localparam int SETS  = 1 << SET_W
) (
   input  logic                                    clk,
   input  logic                                    rst,
   input  logic                                    upd_valid,
   input  logic                                    upd_fill,
   input  logic [ADDR_W-1:0]                       upd_addr,
   input  logic [WAY_W-1:0]                        upd_way,
   output logic                                    pend_valid,
   output logic [SET_W-1:0]                        pend_set,
   input  logic [NBANK-1:0][SET_W-1:0]             rd_set,
   output logic [NBANK-1:0][WAYS-1:0][TAG_W-1:0]   rd_tag,
   output logic [NBANK-1:0][WAYS-1:0]              rd_vld
);
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [WAYS-1:0]  vld_q [SETS];
   upd_kind_e        kind_q;
   logic [TAG_W-1:0] ptag_q;
   logic [WAY_W-1:0] pway_q;

   // Update is staged one cycle, then committed; the top stalls lookups on its set.
   always_ff @(posedge clk) begin
      if (rst) pend_valid <= 1'b0;
      else     pend_valid <= upd_valid;
      kind_q   <= upd_fill ? UPD_LOAD : UPD_DROP;
      pend_set <= upd_addr[SET_W-1:0];
      ptag_q   <= upd_addr[ADDR_W-1:SET_W];
      pway_q   <= upd_way;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (pend_valid) begin
         vld_q[pend_set][pway_q] <= (kind_q == UPD_LOAD);
      end
   end

   always_ff @(posedge clk) begin
      if (pend_valid && kind_q == UPD_LOAD) tag_q[pend_set][pway_q] <= ptag_q;
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_port
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign rd_tag[b][w] = tag_q[rd_set[b]][w];
         assign rd_vld[b][w] = vld_q[rd_set[b]][w];
      end
   end
endmodule

// File: rtl/snpf_bank_pick.sv
module snpf_bank_pick #(
   parameter int NCORE = 4
) (
   input  logic [NCORE-1:0] elig,
   output logic [NCORE-1:0] grant
);
   // Fixed priority: lowest-numbered eligible core wins the bank this cycle.
   always_comb begin
      grant = '0;
      for (int c = 0; c < NCORE; c++) begin
         if (elig[c] && grant == '0) grant[c] = 1'b1;
      end
   end
endmodule

// File: rtl/snpf_probe.sv
module snpf_probe
   import snpf_pkg::*;
#(
   parameter int NCORE  = 4,
   parameter int ADDR_W = 16,
   parameter int SET_W  = 4,
   parameter int WAYS   = 4,
   parameter int PTAG_W = 4,
   parameter int RTAG_W = 4,
   localparam int TAG_W  = ADDR_W - SET_W,
   localparam int CORE_W = clog2_min1(NCORE)
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  in_valid,
   input  logic [CORE_W-1:0]                     in_core,
   input  logic [ADDR_W-1:0]                     in_addr,
   input  logic [RTAG_W-1:0]                     in_rtag,
   output logic                                  rd_en,
   output logic [SET_W-1:0]                      rd_set,
   input  logic [NCORE-1:0][WAYS-1:0][TAG_W-1:0] rd_tag,
   input  logic [NCORE-1:0][WAYS-1:0]            rd_vld,
   output logic                                  out_valid,
   output logic [CORE_W-1:0]                     out_core,
   output logic                                  out_hit,
   output logic [NCORE-1:0]                      out_owner,
   output logic [RTAG_W-1:0]                     out_rtag
);
   // Stage 1: read shadow tags, partial compare, exclude requester.
   logic                s1_v;
   logic [CORE_W-1:0]   s1_core;
   logic [ADDR_W-1:0]   s1_addr;
   logic [RTAG_W-1:0]   s1_rt;
   logic [TAG_W-1:0]    s1_tag;
   logic [NCORE-1:0][WAYS-1:0] cand;

   assign s1_tag = s1_addr[ADDR_W-1:SET_W];
   assign rd_en  = s1_v;
   assign rd_set = s1_addr[SET_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) s1_v <= 1'b0;
      else     s1_v <= in_valid;
      s1_core <= in_core;
      s1_addr <= in_addr;
      s1_rt   <= in_rtag;
   end

   for (genvar c = 0; c < NCORE; c++) begin : g_early
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign cand[c][w] = rd_vld[c][w] && (s1_core != CORE_W'(c)) &&
                             (rd_tag[c][w][PTAG_W-1:0] == s1_tag[PTAG_W-1:0]);
      end
   end

   // Stage 2: confirm candidates against the full tag.
   logic                                  s2_v;
   logic [CORE_W-1:0]                     s2_core;
   logic [TAG_W-1:0]                      s2_tag;
   logic [RTAG_W-1:0]                     s2_rt;
   logic [NCORE-1:0][WAYS-1:0]            s2_cand;
   logic [NCORE-1:0][WAYS-1:0][TAG_W-1:0] s2_tags;
   logic [NCORE-1:0][WAYS-1:0]            full_m;
   logic [NCORE-1:0]                      hold;
   logic [NCORE-1:0]                      own;

   always_ff @(posedge clk) begin
      if (rst) s2_v <= 1'b0;
      else     s2_v <= s1_v;
      s2_core <= s1_core;
      s2_tag  <= s1_tag;
      s2_rt   <= s1_rt;
      s2_cand <= cand;
      s2_tags <= rd_tag;
   end

   for (genvar c = 0; c < NCORE; c++) begin : g_late
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign full_m[c][w] = s2_cand[c][w] && (s2_tags[c][w] == s2_tag);
      end
      assign hold[c] = |full_m[c];
   end

   always_comb begin
      own = '0;
      for (int c = 0; c < NCORE; c++) begin
         if (hold[c] && own == '0) own[c] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= s2_v;
      out_core  <= s2_core;
      out_hit   <= |own;
      out_owner <= own;
      out_rtag  <= s2_rt;
   end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
   import snpf_pkg::*;
#(
   parameter int NCORE  = 4,
   parameter int ADDR_W = 16,
   parameter int SET_W  = 4,
   parameter int WAYS   = 4,
   parameter int NBANK  = 4,
   parameter int PTAG_W = 4,
   parameter int RTAG_W = 4,
   localparam int TAG_W  = ADDR_W - SET_W,
   localparam int WAY_W  = clog2_min1(WAYS),
   localparam int CORE_W = clog2_min1(NCORE),
   localparam int BANK_W = clog2_min1(NBANK)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [NCORE-1:0]              req_valid,
   output logic [NCORE-1:0]              req_ready,
   input  logic [NCORE-1:0][ADDR_W-1:0]  req_addr,
   input  logic [NCORE-1:0][RTAG_W-1:0]  req_rtag,
   input  logic [NCORE-1:0]              upd_valid,
   input  logic [NCORE-1:0]              upd_fill,
   input  logic [NCORE-1:0][ADDR_W-1:0]  upd_addr,
   input  logic [NCORE-1:0][WAY_W-1:0]   upd_way,
   output logic [NCORE-1:0]              rsp_valid,
   output logic [NCORE-1:0]              rsp_hit,
   output logic [NCORE-1:0][NCORE-1:0]   rsp_owner,
   output logic [NCORE-1:0][RTAG_W-1:0]  rsp_rtag
);
   if (NCORE < 2)                      begin : g_bad_core $error("NCORE must be at least 2"); end
   if (NBANK < 2 || (1 << BANK_W) != NBANK) begin : g_bad_bank $error("NBANK must be a power of two >= 2"); end
   if (BANK_W > SET_W)                 begin : g_bad_set  $error("bank bits must lie inside the set index"); end
   if (PTAG_W < 1 || PTAG_W > TAG_W)   begin : g_bad_ptag $error("PTAG_W out of range"); end

   // Shadow arrays, one per core, each with a read port per bank.
   logic [NCORE-1:0]                                  pend_v;
   logic [NCORE-1:0][SET_W-1:0]                       pend_set;
   logic [NBANK-1:0][SET_W-1:0]                       bank_set;
   logic [NBANK-1:0]                                  bank_rd;
   logic [NCORE-1:0][NBANK-1:0][WAYS-1:0][TAG_W-1:0]  arr_tag;
   logic [NCORE-1:0][NBANK-1:0][WAYS-1:0]             arr_vld;
   logic [NBANK-1:0][NCORE-1:0][WAYS-1:0][TAG_W-1:0]  bank_tag;
   logic [NBANK-1:0][NCORE-1:0][WAYS-1:0]             bank_vld;

   for (genvar c = 0; c < NCORE; c++) begin : g_arr
      snpf_dup_array #(.ADDR_W(ADDR_W), .SET_W(SET_W), .WAYS(WAYS), .NBANK(NBANK)) u_arr (
         .clk(clk), .rst(rst),
         .upd_valid(upd_valid[c]), .upd_fill(upd_fill[c]),
         .upd_addr(upd_addr[c]), .upd_way(upd_way[c]),
         .pend_valid(pend_v[c]), .pend_set(pend_set[c]),
         .rd_set(bank_set), .rd_tag(arr_tag[c]), .rd_vld(arr_vld[c]));
   end

   always_comb begin
      for (int b = 0; b < NBANK; b++) begin
         for (int c = 0; c < NCORE; c++) begin
            bank_tag[b][c] = arr_tag[c][b];
            bank_vld[b][c] = arr_vld[c][b];
         end
      end
   end

   // Consistency window: block a request whose set has an update arriving or pending.
   logic [NCORE-1:0] blocked;
   always_comb begin
      for (int c = 0; c < NCORE; c++) begin
         blocked[c] = 1'b0;
         for (int k = 0; k < NCORE; k++) begin
            if ((upd_valid[k] && upd_addr[k][SET_W-1:0] == req_addr[c][SET_W-1:0]) ||
                (pend_v[k] && pend_set[k] == req_addr[c][SET_W-1:0]))
               blocked[c] = 1'b1;
         end
      end
   end

   // Per-bank arbitration and lookup pipelines.
   logic [NBANK-1:0][NCORE-1:0]  elig, grant, in_bank;
   logic [NBANK-1:0]             in_v, out_v, out_hit;
   logic [NBANK-1:0][CORE_W-1:0] in_core, out_core;
   logic [NBANK-1:0][ADDR_W-1:0] in_addr;
   logic [NBANK-1:0][RTAG_W-1:0] in_rt, out_rt;
   logic [NBANK-1:0][NCORE-1:0]  out_own;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      for (genvar c = 0; c < NCORE; c++) begin : g_el
         assign in_bank[b][c] = req_valid[c] && (req_addr[c][BANK_W-1:0] == BANK_W'(b));
         assign elig[b][c]    = in_bank[b][c] && !blocked[c];
      end

      snpf_bank_pick #(.NCORE(NCORE)) u_pick (.elig(elig[b]), .grant(grant[b]));

      always_comb begin
         in_core[b] = '0;
         in_addr[b] = '0;
         in_rt[b]   = '0;
         for (int c = 0; c < NCORE; c++) begin
            if (grant[b][c]) begin
               in_core[b] = CORE_W'(c);
               in_addr[b] = req_addr[c];
               in_rt[b]   = req_rtag[c];
            end
         end
      end
      assign in_v[b] = |grant[b];

      snpf_probe #(.NCORE(NCORE), .ADDR_W(ADDR_W), .SET_W(SET_W), .WAYS(WAYS),
                   .PTAG_W(PTAG_W), .RTAG_W(RTAG_W)) u_probe (
         .clk(clk), .rst(rst),
         .in_valid(in_v[b]), .in_core(in_core[b]), .in_addr(in_addr[b]), .in_rtag(in_rt[b]),
         .rd_en(bank_rd[b]), .rd_set(bank_set[b]),
         .rd_tag(bank_tag[b]), .rd_vld(bank_vld[b]),
         .out_valid(out_v[b]), .out_core(out_core[b]), .out_hit(out_hit[b]),
         .out_owner(out_own[b]), .out_rtag(out_rt[b]));

      // R6: one acceptance per bank per cycle.
      a_r6_one_per_bank: assert property (@(posedge clk) disable iff (rst)
         $countones(req_ready & in_bank[b]) <= 1);

      // R8: a stage-one read never meets an uncommitted update to its set.
      for (genvar k = 0; k < NCORE; k++) begin : g_win
         a_r8_no_stale_read: assert property (@(posedge clk) disable iff (rst)
            bank_rd[b] |-> !(pend_v[k] && pend_set[k] == bank_set[b]));
      end
   end

   always_comb begin
      for (int c = 0; c < NCORE; c++) begin
         req_ready[c] = 1'b0;
         for (int b = 0; b < NBANK; b++) req_ready[c] = req_ready[c] | grant[b][c];
      end
   end

   // Route each bank's result to the port of the requesting core.
   always_comb begin
      rsp_valid = '0;
      rsp_hit   = '0;
      rsp_owner = '0;
      rsp_rtag  = '0;
      for (int b = 0; b < NBANK; b++) begin
         for (int c = 0; c < NCORE; c++) begin
            if (out_v[b] && out_core[b] == CORE_W'(c)) begin
               rsp_valid[c] = 1'b1;
               rsp_hit[c]   = out_hit[b];
               rsp_owner[c] = out_own[b];
               rsp_rtag[c]  = out_rt[b];
            end
         end
      end
   end

   for (genvar c = 0; c < NCORE; c++) begin : g_rsp_chk
      a_r1_latency: assert property (@(posedge clk) disable iff (rst)
         rsp_valid[c] |-> $past(req_valid[c] && req_ready[c], 3));
      a_r2_owner_shape: assert property (@(posedge clk) disable iff (rst)
         rsp_valid[c] |-> ($onehot0(rsp_owner[c]) && (rsp_hit[c] == (|rsp_owner[c]))));
      a_r3_not_self: assert property (@(posedge clk) disable iff (rst)
         rsp_valid[c] |-> !rsp_owner[c][c]);
   end
endmodule

// File: tb/snoop_filter_test.sv
module snoop_filter_test;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [3:0]       req_valid = '0;
   logic [3:0]       req_ready;
   logic [3:0][15:0] req_addr = '0;
   logic [3:0][3:0]  req_rtag = '0;
   logic [3:0]       upd_valid = '0;
   logic [3:0]       upd_fill = '0;
   logic [3:0][15:0] upd_addr = '0;
   logic [3:0][1:0]  upd_way = '0;
   logic [3:0]       rsp_valid;
   logic [3:0]       rsp_hit;
   logic [3:0][3:0]  rsp_owner;
   logic [3:0][3:0]  rsp_rtag;

   snoop_filter uut (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_rtag(req_rtag),
      .upd_valid(upd_valid), .upd_fill(upd_fill), .upd_addr(upd_addr), .upd_way(upd_way),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_owner(rsp_owner), .rsp_rtag(rsp_rtag));

   always #(CLK_P/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int         core;
      bit         hit;
      logic [3:0] own;
      logic [3:0] rt;
      int         when;
   } exp_t;
   exp_t sbq[$];

   logic [11:0] mtag [4][16][4];
   bit          mval [4][16][4];
   int          start_cyc [4];
   int          acc_cyc [4];
   bit          last_hit [4];
   logic [3:0]  last_own [4];

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic void predict(int c, logic [15:0] a, output bit h, output logic [3:0] own);
      h = 0;
      own = '0;
      for (int k = 0; k < 4; k++) begin
         if (k != c && !h) begin
            for (int w = 0; w < 4; w++) begin
               if (mval[k][a[3:0]][w] && mtag[k][a[3:0]][w] == a[15:4]) h = 1;
            end
            if (h) own[k] = 1'b1;
         end
      end
   endfunction

   task automatic upd(int c, bit fill, logic [15:0] a, int w);
      @(negedge clk);
      upd_valid[c] = 1'b1;
      upd_fill[c]  = fill;
      upd_addr[c]  = a;
      upd_way[c]   = w[1:0];
      mval[c][a[3:0]][w] = fill;
      if (fill) mtag[c][a[3:0]][w] = a[15:4];
      @(posedge clk);
      #1 upd_valid[c] = 1'b0;
   endtask

   task automatic issue(int c, logic [15:0] a, logic [3:0] rt);
      bit rdy;
      exp_t e;
      @(negedge clk);
      req_valid[c] = 1'b1;
      req_addr[c]  = a;
      req_rtag[c]  = rt;
      start_cyc[c] = cyc;
      forever begin
         #1 rdy = req_ready[c];
         @(posedge clk);
         if (rdy) break;
         @(negedge clk);
      end
      #1;
      acc_cyc[c] = cyc;
      e.core = c;
      predict(c, a, e.hit, e.own);
      e.rt   = rt;
      e.when = cyc + 2;
      sbq.push_back(e);
      req_valid[c] = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   // Monitor: pop the oldest expectation for each responding core.
   always @(negedge clk) begin
      if (!rst) begin
         for (int c = 0; c < 4; c++) begin
            if (rsp_valid[c]) begin
               int idx = -1;
               for (int i = 0; i < sbq.size(); i++) begin
                  if (idx < 0 && sbq[i].core == c) idx = i;
               end
               if (idx < 0) begin
                  chk(0, "R10", "unexpected response core", c, -1);
               end else begin
                  chk(rsp_hit[c] == sbq[idx].hit, "R2", "hit", int'(rsp_hit[c]), int'(sbq[idx].hit));
                  chk(rsp_owner[c] == sbq[idx].own, "R2", "owner", int'(rsp_owner[c]), int'(sbq[idx].own));
                  chk(rsp_rtag[c] == sbq[idx].rt, "R1", "rtag", int'(rsp_rtag[c]), int'(sbq[idx].rt));
                  chk(cyc == sbq[idx].when, "R1", "latency cycle", cyc, sbq[idx].when);
                  last_hit[c] = rsp_hit[c];
                  last_own[c] = rsp_owner[c];
                  sbq.delete(idx);
               end
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < 4; c++)
         for (int s = 0; s < 16; s++)
            for (int w = 0; w < 4; w++) begin
               mval[c][s][w] = 0;
               mtag[c][s][w] = '0;
            end
      repeat (3) @(negedge clk);
      chk(rsp_valid == '0, "R9", "rsp_valid in reset", int'(rsp_valid), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(rsp_valid == '0, "R9", "rsp_valid after reset", int'(rsp_valid), 0);

      // R9: empty arrays miss
      issue(0, 16'h1230, 4'h1); settle();
      chk(last_hit[0] == 0, "R9", "empty lookup hit", int'(last_hit[0]), 0);

      // R4 / R2: fill in core1 seen by core0
      upd(1, 1, 16'h1230, 2);
      issue(0, 16'h1230, 4'h2); settle();
      chk(last_own[0] == 4'b0010, "R4", "owner after fill", int'(last_own[0]), 2);

      // R3: core1 asking for its own line misses
      issue(1, 16'h1230, 4'h3); settle();
      chk(last_hit[1] == 0, "R3", "own array ignored", int'(last_hit[1]), 0);

      // R2: lowest-numbered holder wins
      upd(3, 1, 16'h4567, 0);
      upd(2, 1, 16'h4567, 3);
      issue(0, 16'h4567, 4'h4); settle();
      chk(last_own[0] == 4'b0100, "R2", "lowest owner", int'(last_own[0]), 4);
      issue(2, 16'h4567, 4'h5); settle();
      chk(last_own[2] == 4'b1000, "R3", "self skipped owner", int'(last_own[2]), 8);

      // R4: eviction clears the entry
      upd(1, 0, 16'h1230, 2);
      issue(0, 16'h1230, 4'h6); settle();
      chk(last_hit[0] == 0, "R4", "hit after evict", int'(last_hit[0]), 0);

      // R5: partial-tag alias does not hit
      upd(1, 1, 16'h1235, 1);
      issue(2, 16'h2235, 4'h7); settle();
      chk(last_hit[2] == 0, "R5", "alias hit", int'(last_hit[2]), 0);
      issue(2, 16'h1235, 4'h8); settle();
      chk(last_own[2] == 4'b0010, "R5", "full match owner", int'(last_own[2]), 2);

      // R4: refill of same way replaces the tag
      upd(1, 1, 16'h9995, 1);
      issue(0, 16'h1235, 4'h9); settle();
      chk(last_hit[0] == 0, "R4", "replaced tag hit", int'(last_hit[0]), 0);
      issue(0, 16'h9995, 4'hA); settle();
      chk(last_own[0] == 4'b0010, "R4", "new tag owner", int'(last_own[0]), 2);

      // R6: same bank conflict (sets 1 and 5, bank 1)
      fork
         issue(0, 16'h0001, 4'hB);
         issue(1, 16'h0005, 4'hC);
      join
      chk(acc_cyc[0] - start_cyc[0] == 1, "R6", "winner delay", acc_cyc[0] - start_cyc[0], 1);
      chk(acc_cyc[1] - start_cyc[1] == 2, "R6", "loser delay", acc_cyc[1] - start_cyc[1], 2);
      settle();

      // R7: different banks in parallel
      fork
         issue(2, 16'h0002, 4'hD);
         issue(3, 16'h0003, 4'hE);
      join
      chk(acc_cyc[2] - start_cyc[2] == 1, "R7", "bank2 delay", acc_cyc[2] - start_cyc[2], 1);
      chk(acc_cyc[3] - start_cyc[3] == 1, "R7", "bank3 delay", acc_cyc[3] - start_cyc[3], 1);
      settle();

      // R8: update to the same set stalls the lookup
      fork
         upd(2, 1, 16'h7778, 0);
         issue(0, 16'h7778, 4'hF);
      join
      chk(acc_cyc[0] - start_cyc[0] == 3, "R8", "stall delay", acc_cyc[0] - start_cyc[0], 3);
      settle();
      chk(last_own[0] == 4'b0100, "R8", "result after commit", int'(last_own[0]), 4);

      // R8: update to another set does not stall
      fork
         upd(2, 1, 16'h7779, 1);
         issue(0, 16'h777A, 4'h0);
      join
      chk(acc_cyc[0] - start_cyc[0] == 1, "R8", "no stall other set", acc_cyc[0] - start_cyc[0], 1);
      settle();

      chk(sbq.size() == 0, "R10", "responses outstanding", sbq.size(), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule